// File: doc/BRIEF.md
# Cache Tag and Data Inspection Port

This block holds the storage of a four-way, 256-set cache with 16-byte lines: a tag array, per-line valid and lock bits, a data array, and a pairwise LRU tracker for each set. Software inspects this storage through two registers. It first writes a diagnostic address register. That value selects the array, way, set and word. It then reads the data register. One cycle after the read strobe the block returns either one 32-bit word of the selected line or a packed word. The packed word holds the tag, the valid and lock bits, and the set's LRU code.

A line fill port and a lookup port exist only so that a test can load the arrays and move the LRU state. A fill writes a whole line with its tag and lock bit and marks the line valid. A lookup compares a line address against the four ways of its set. A hit makes the hitting way the most recent. Diagnostic traffic never counts as an access.

Bit positions in this brief are given little-endian: bit 31 is the most significant bit of a 32-bit word.

Top module: `cache_diag_port`

## Requirements
- R1: After reset, regRdValid and lookupHit are 0, the address register reads 0, and every tag word reads 0 (tag 0, invalid, unlocked, LRU code 0).
- R2: A write with regAddrSel=0 stores only bits 14:2 of regWrData into the address register. Bits 31:15 and 1:0 read back as 0. A read with regAddrSel=0 returns the register one cycle after the strobe.
- R3: Every read strobe is answered by a one-cycle regRdValid pulse and data in the next cycle. With regAddrSel=1 and address bit 14 = 1, the read returns word [3:2] of the line in way [13:12] and set [11:4]. Word k of a line is fillLine[32k+31:32k].
- R4: With regAddrSel=1 and address bit 14 = 0, the read returns the tag in 31:12, valid in 9, lock in 8, the LRU code in 7:2, and zeros in 11:10 and 1:0.
- R5: Each LRU code bit records that one way is more recent than another. Bit 7: way1 over way0. Bit 6: way2 over way0. Bit 5: way2 over way1. Bit 4: way3 over way0. Bit 3: way3 over way1. Bit 2: way3 over way2. Touching way w makes w more recent than the other three and leaves the other pairs unchanged.
- R6: Diagnostic reads and address-register writes change no tag, data, valid, lock or LRU state.
- R7: A fill writes tag fillLineAddr[27:8] and the line into way fillWay of set fillLineAddr[7:0]. It sets the line valid, sets its lock bit to fillLock, and touches that way in the LRU state.
- R8: lookupHit is 1 one cycle after lookupEn exactly when a valid way of set lookupLineAddr[7:0] holds tag lookupLineAddr[27:8]. lookupWay names the lowest such way. A hit touches that way. A miss, or a cycle without lookupEn, changes no LRU state and leaves lookupHit at 0.
- R9: A read, lookup or fill in the same cycle sees the state from before that cycle's updates. When a fill and a lookup hit happen together, only the fill's way is touched.
- R10: A write with regAddrSel=1 has no effect on the address register or the arrays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddrSel | input | 1 | 0 selects the address register, 1 the data register |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid with regRdValid |
| regRdValid | output | 1 | Read data valid, one cycle after regRdEn |
| fillEn | input | 1 | Line fill strobe |
| fillWay | input | 2 | Way to fill |
| fillLineAddr | input | 28 | Tag (27:8) and set (7:0) of the fill |
| fillLine | input | 128 | Line contents, word k at bits 32k+31:32k |
| fillLock | input | 1 | Lock bit written by the fill |
| lookupEn | input | 1 | Lookup strobe |
| lookupLineAddr | input | 28 | Tag (27:8) and set (7:0) to look up |
| lookupHit | output | 1 | Lookup hit, one cycle after lookupEn |
| lookupWay | output | 2 | Lowest hitting way |

## Verification
On every cycle the assertions check several timing and format rules. Each read strobe must be followed by exactly one valid pulse and no other. The reserved bits of address-register readback and of tag words must be zero. No LRU update may happen in a cycle with only register traffic, and lookupHit must stay low without a lookup. Several behaviours can only be shown by the bench's scenarios against its recency-list model. These include the exact values of tag words and LRU codes after chains of fills and hits, and the lowest-way choice among duplicate tags. They also include the same-cycle fill, lookup and read case, and the fact that a long run of diagnostic traffic leaves the LRU codes unchanged.

// File: rtl/cdr_pkg.sv
`timescale 1ns/1ps
package cdr_pkg;
  parameter int ADDR_W = 32;
  parameter int OFF_W  = 4;
  parameter int SET_W  = 8;
  parameter int WAYS   = 4;
  parameter int WORD_W = 32;

  localparam int WAY_W       = $clog2(WAYS);
  localparam int SETS        = 1 << SET_W;
  localparam int TAG_W       = ADDR_W - SET_W - OFF_W;
  localparam int LADDR_W     = TAG_W + SET_W;
  localparam int BYTE_SEL_W  = $clog2(WORD_W / 8);
  localparam int WORDS       = (1 << OFF_W) / (WORD_W / 8);
  localparam int WSEL_W      = $clog2(WORDS);
  localparam int LINE_W      = WORDS * WORD_W;
  localparam int LRU_W       = WAYS * (WAYS - 1) / 2;

  // field positions of the diagnostic address register (LSB numbering)
  localparam int WSEL_LSB    = BYTE_SEL_W;
  localparam int SET_LSB     = OFF_W;
  localparam int WAY_LSB     = OFF_W + SET_W;
  localparam int ARR_BIT     = WAY_LSB + WAY_W;
  localparam logic [ADDR_W-1:0] KEEP_MASK =
    ADDR_W'(((64'd1 << (ARR_BIT + 1)) - 64'd1) & ~((64'd1 << WSEL_LSB) - 64'd1));

  typedef struct packed {
    logic             addrWr;
    logic             rdAddr;
    logic             rdArray;
    logic             fillWr;
    logic             lookupSample;
    logic             lruTouch;
    logic [WAY_W-1:0] lruWay;
  } ctlStrobe_t;
endpackage

// File: rtl/cdr_lru.sv
`timescale 1ns/1ps
module cdr_lru
  import cdr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             touchEn,
  input  logic [SET_W-1:0] touchSet,
  input  logic [WAY_W-1:0] touchWay,
  input  logic [SET_W-1:0] rdSet,
  output logic [LRU_W-1:0] rdCode
);
  logic [LRU_W-1:0] codeMem [SETS];

  // pairs (i,j), i<j, walked j-outer/i-inner from the MSB down; bit set => j newer than i
  function automatic logic [LRU_W-1:0] promote(input logic [LRU_W-1:0] cur,
                                               input logic [WAY_W-1:0] way);
    logic [LRU_W-1:0] nxt;
    int idx;
    nxt = cur;
    idx = LRU_W - 1;
    for (int j = 1; j < WAYS; j++) begin
      for (int i = 0; i < j; i++) begin
        if (int'(way) == j) nxt[idx] = 1'b1;
        else if (int'(way) == i) nxt[idx] = 1'b0;
        idx--;
      end
    end
    return nxt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) codeMem[s] <= '0;
    end else if (touchEn) begin
      codeMem[touchSet] <= promote(codeMem[touchSet], touchWay);
    end
  end

  assign rdCode = codeMem[rdSet];
endmodule

// File: rtl/cdr_control.sv
`timescale 1ns/1ps
module cdr_control
  import cdr_pkg::*;
(
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic             regAddrSel,
  input  logic             fillEn,
  input  logic [WAY_W-1:0] fillWay,
  input  logic             lookupEn,
  input  logic             hitAny,
  input  logic [WAY_W-1:0] hitWay,
  output ctlStrobe_t       ctl
);
  always_comb begin
    ctl.addrWr       = regWrEn & ~regAddrSel;
    ctl.rdAddr       = regRdEn & ~regAddrSel;
    ctl.rdArray      = regRdEn & regAddrSel;
    ctl.fillWr       = fillEn;
    ctl.lookupSample = lookupEn;
    // a fill owns the LRU update; diagnostic traffic never touches it
    ctl.lruTouch     = fillEn | (lookupEn & hitAny);
    ctl.lruWay       = fillEn ? fillWay : hitWay;
  end
endmodule

// File: rtl/cdr_datapath.sv
`timescale 1ns/1ps
module cdr_datapath
  import cdr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [ADDR_W-1:0]  regWrData,
  input  logic [WAY_W-1:0]   fillWay,
  input  logic [LADDR_W-1:0] fillLineAddr,
  input  logic [LINE_W-1:0]  fillLine,
  input  logic               fillLock,
  input  logic [LADDR_W-1:0] lookupLineAddr,
  input  logic [LRU_W-1:0]   lruCode,
  output logic [ADDR_W-1:0]  regRdData,
  output logic               regRdValid,
  output logic               lookupHit,
  output logic [WAY_W-1:0]   lookupWay,
  output logic               hitAny,
  output logic [WAY_W-1:0]   hitWay,
  output logic [SET_W-1:0]   lruTouchSet,
  output logic [SET_W-1:0]   lruRdSet,
  output logic [ADDR_W-1:0]  diagAddr
);
  logic [TAG_W-1:0]  tagMem  [WAYS][SETS];
  logic [LINE_W-1:0] dataMem [WAYS][SETS];
  logic [SETS-1:0]   validVec [WAYS];
  logic [SETS-1:0]   lockVec  [WAYS];
  logic [ADDR_W-1:0] addrReg;

  logic [SET_W-1:0]  fillSet, lkSet, diagSet;
  logic [TAG_W-1:0]  fillTag, lkTag;
  logic [WAY_W-1:0]  diagWay;
  logic [WSEL_W-1:0] diagWord;
  logic              diagIsData;
  logic [WAYS-1:0]   hitVec;
  logic [LINE_W-1:0] diagLine;
  logic [WORD_W-1:0] dataWord, tagWord;

  assign fillSet    = fillLineAddr[SET_W-1:0];
  assign fillTag    = fillLineAddr[LADDR_W-1:SET_W];
  assign lkSet      = lookupLineAddr[SET_W-1:0];
  assign lkTag      = lookupLineAddr[LADDR_W-1:SET_W];
  assign diagIsData = addrReg[ARR_BIT];
  assign diagWay    = addrReg[WAY_LSB +: WAY_W];
  assign diagSet    = addrReg[SET_LSB +: SET_W];
  assign diagWord   = addrReg[WSEL_LSB +: WSEL_W];

  // diagnostic address register
  always_ff @(posedge clk) begin
    if (!rstN) addrReg <= '0;
    else if (ctl.addrWr) addrReg <= regWrData & KEEP_MASK;
  end

  // tag, valid and lock state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) begin
        validVec[w] <= '0;
        lockVec[w]  <= '0;
        for (int s = 0; s < SETS; s++) tagMem[w][s] <= '0;
      end
    end else if (ctl.fillWr) begin
      tagMem[fillWay][fillSet]   <= fillTag;
      validVec[fillWay][fillSet] <= 1'b1;
      lockVec[fillWay][fillSet]  <= fillLock;
    end
  end

  // line data, never reset
  always_ff @(posedge clk) begin
    if (ctl.fillWr) dataMem[fillWay][fillSet] <= fillLine;
  end

  // per-way compare
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validVec[w][lkSet] && (tagMem[w][lkSet] == lkTag);
  end

  always_comb begin
    hitAny = 1'b0;
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        hitAny = 1'b1;
        hitWay = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookupHit <= 1'b0;
      lookupWay <= '0;
    end else begin
      lookupHit <= ctl.lookupSample & hitAny;
      lookupWay <= (ctl.lookupSample & hitAny) ? hitWay : '0;
    end
  end

  // diagnostic read path
  assign diagLine = dataMem[diagWay][diagSet];
  assign dataWord = diagLine[int'(diagWord) * WORD_W +: WORD_W];
  assign tagWord  = {tagMem[diagWay][diagSet], 2'b00,
                     validVec[diagWay][diagSet], lockVec[diagWay][diagSet],
                     lruCode, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= ctl.rdAddr | ctl.rdArray;
      if (ctl.rdAddr) regRdData <= addrReg;
      else if (ctl.rdArray) regRdData <= diagIsData ? dataWord : tagWord;
    end
  end

  assign lruTouchSet = ctl.fillWr ? fillSet : lkSet;
  assign lruRdSet    = diagSet;
  assign diagAddr    = addrReg;
endmodule

// File: rtl/cache_diag_port.sv
`timescale 1ns/1ps
module cache_diag_port
  import cdr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic               regAddrSel,
  input  logic [ADDR_W-1:0]  regWrData,
  output logic [ADDR_W-1:0]  regRdData,
  output logic               regRdValid,
  input  logic               fillEn,
  input  logic [WAY_W-1:0]   fillWay,
  input  logic [LADDR_W-1:0] fillLineAddr,
  input  logic [LINE_W-1:0]  fillLine,
  input  logic               fillLock,
  input  logic               lookupEn,
  input  logic [LADDR_W-1:0] lookupLineAddr,
  output logic               lookupHit,
  output logic [WAY_W-1:0]   lookupWay
);
  ctlStrobe_t        ctl;
  logic              hitAny;
  logic [WAY_W-1:0]  hitWay;
  logic [SET_W-1:0]  lruTouchSet, lruRdSet;
  logic [LRU_W-1:0]  lruCode;
  logic [ADDR_W-1:0] diagAddr;
  logic              lruTouch;

  assign lruTouch = ctl.lruTouch;

  cdr_control u_ctl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddrSel(regAddrSel),
    .fillEn(fillEn), .fillWay(fillWay), .lookupEn(lookupEn),
    .hitAny(hitAny), .hitWay(hitWay), .ctl(ctl)
  );

  cdr_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regWrData(regWrData),
    .fillWay(fillWay), .fillLineAddr(fillLineAddr), .fillLine(fillLine),
    .fillLock(fillLock), .lookupLineAddr(lookupLineAddr), .lruCode(lruCode),
    .regRdData(regRdData), .regRdValid(regRdValid),
    .lookupHit(lookupHit), .lookupWay(lookupWay),
    .hitAny(hitAny), .hitWay(hitWay),
    .lruTouchSet(lruTouchSet), .lruRdSet(lruRdSet), .diagAddr(diagAddr)
  );

  cdr_lru u_lru (
    .clk(clk), .rstN(rstN), .touchEn(lruTouch), .touchSet(lruTouchSet),
    .touchWay(ctl.lruWay), .rdSet(lruRdSet), .rdCode(lruCode)
  );
endmodule

// File: rtl/cdr_checker.sv
`timescale 1ns/1ps
module cdr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regRdEn,
  input logic        regAddrSel,
  input logic        regRdValid,
  input logic [31:0] regRdData,
  input logic        lookupEn,
  input logic        lookupHit,
  input logic        fillEn,
  input logic [31:0] diagAddr,
  input logic        lruTouch
);
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid); // R3
  AST_RD_VALID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> !regRdValid); // R3
  AST_ADDR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regAddrSel) |=> (regRdData[31:15] == '0 && regRdData[1:0] == '0)); // R2
  AST_TAG_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddrSel && !diagAddr[14]) |=> (regRdData[11:10] == '0 && regRdData[1:0] == '0)); // R4
  AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !lookupEn |=> !lookupHit); // R8
  AST_DIAG_NO_LRU: assert property (@(posedge clk) disable iff (!rstN)
    (!fillEn && !lookupEn) |-> !lruTouch); // R6
endmodule

bind cache_diag_port cdr_checker u_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regAddrSel(regAddrSel),
  .regRdValid(regRdValid), .regRdData(regRdData), .lookupEn(lookupEn),
  .lookupHit(lookupHit), .fillEn(fillEn), .diagAddr(diagAddr), .lruTouch(lruTouch)
);

// File: tb/sim_cache_diag_port.sv
`timescale 1ns/1ps
module sim_cache_diag_port;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0, regRdEn = 1'b0, regAddrSel = 1'b0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         regRdValid;
  logic         fillEn = 1'b0, fillLock = 1'b0;
  logic [1:0]   fillWay = '0;
  logic [27:0]  fillLineAddr = '0;
  logic [127:0] fillLine = '0;
  logic         lookupEn = 1'b0;
  logic [27:0]  lookupLineAddr = '0;
  logic         lookupHit;
  logic [1:0]   lookupWay;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cache_diag_port u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddrSel(regAddrSel), .regWrData(regWrData), .regRdData(regRdData),
    .regRdValid(regRdValid), .fillEn(fillEn), .fillWay(fillWay),
    .fillLineAddr(fillLineAddr), .fillLine(fillLine), .fillLock(fillLock),
    .lookupEn(lookupEn), .lookupLineAddr(lookupLineAddr),
    .lookupHit(lookupHit), .lookupWay(lookupWay)
  );

  // reference model
  logic [19:0] mTag   [4][256];
  logic        mValid [4][256];
  logic        mLock  [4][256];
  logic [31:0] mData  [4][256][4];
  int          rec    [256][4];   // recency list, most recent first
  logic [31:0] mAddr;

  function automatic int posOf(int s, int w);
    for (int k = 0; k < 4; k++) if (rec[s][k] == w) return k;
    return 0;
  endfunction

  function automatic logic [5:0] lruCode(int s);
    return {posOf(s,1) < posOf(s,0), posOf(s,2) < posOf(s,0), posOf(s,2) < posOf(s,1),
            posOf(s,3) < posOf(s,0), posOf(s,3) < posOf(s,1), posOf(s,3) < posOf(s,2)};
  endfunction

  task automatic touch(int s, int w);
    int p;
    p = posOf(s, w);
    for (int k = p; k > 0; k--) rec[s][k] = rec[s][k-1];
    rec[s][0] = w;
  endtask

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic tick(string rq);
    logic        expV, expH;
    logic [31:0] expD;
    logic [1:0]  expW;
    int s, w, k;
    expV = regRdEn;
    expD = '0;
    if (regRdEn) begin
      if (!regAddrSel) expD = mAddr;
      else begin
        w = int'(mAddr[13:12]); s = int'(mAddr[11:4]); k = int'(mAddr[3:2]);
        if (mAddr[14]) expD = mData[w][s][k];
        else expD = {mTag[w][s], 2'b00, mValid[w][s], mLock[w][s], lruCode(s), 2'b00};
      end
    end
    expH = 1'b0; expW = '0;
    if (lookupEn) begin
      s = int'(lookupLineAddr[7:0]);
      for (int i = 3; i >= 0; i--)
        if (mValid[i][s] && mTag[i][s] == lookupLineAddr[27:8]) begin
          expH = 1'b1; expW = 2'(i);
        end
    end
    if (regWrEn && !regAddrSel) mAddr = regWrData & 32'h0000_7FFC;
    if (fillEn) begin
      s = int'(fillLineAddr[7:0]); w = int'(fillWay);
      mTag[w][s] = fillLineAddr[27:8];
      mValid[w][s] = 1'b1;
      mLock[w][s] = fillLock;
      for (int q = 0; q < 4; q++) mData[w][s][q] = fillLine[32*q +: 32];
      touch(s, w);
    end else if (expH) begin
      touch(int'(lookupLineAddr[7:0]), int'(expW));
    end
    @(posedge clk); #2;
    chk(rq, "regRdValid", 32'(regRdValid), 32'(expV));
    if (expV) chk(rq, "regRdData", regRdData, expD);
    chk(rq, "lookupHit", 32'(lookupHit), 32'(expH));
    if (expH) chk(rq, "lookupWay", 32'(lookupWay), 32'(expW));
    regWrEn = 0; regRdEn = 0; regAddrSel = 0; regWrData = '0;
    fillEn = 0; fillLock = 0; fillWay = '0; fillLineAddr = '0; fillLine = '0;
    lookupEn = 0; lookupLineAddr = '0;
  endtask

  function automatic logic [31:0] mkDiag(bit isData, int way, int set, int word);
    return {17'b0, isData, 2'(way), 8'(set), 2'(word), 2'b00};
  endfunction

  function automatic logic [127:0] mkLine(int seed);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[32*k +: 32] = 32'(seed * 32'h0001_0003 + k * 32'h1111_0000);
    return l;
  endfunction

  task automatic wrAddr(logic [31:0] v, string rq);
    regWrEn = 1; regAddrSel = 0; regWrData = v; tick(rq);
  endtask

  task automatic rdReg(bit sel, string rq);
    regRdEn = 1; regAddrSel = sel; tick(rq);
  endtask

  task automatic diagRead(bit isData, int way, int set, int word, string rq);
    wrAddr(mkDiag(isData, way, set, word), rq);
    rdReg(1, rq);
  endtask

  task automatic doFill(int way, logic [19:0] tag, int set, int seed, bit lock, string rq);
    fillEn = 1; fillWay = 2'(way); fillLineAddr = {tag, 8'(set)};
    fillLine = mkLine(seed); fillLock = lock; tick(rq);
  endtask

  task automatic doLookup(logic [19:0] tag, int set, string rq);
    lookupEn = 1; lookupLineAddr = {tag, 8'(set)}; tick(rq);
  endtask

  initial begin
    mAddr = '0;
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 256; s++) begin
        mTag[w][s] = '0; mValid[w][s] = 0; mLock[w][s] = 0;
      end
    for (int s = 0; s < 256; s++)
      for (int k = 0; k < 4; k++) rec[s][k] = k;

    repeat (3) @(posedge clk);
    #2 rstN = 1;
    tick("R1");
    rdReg(0, "R1");
    diagRead(0, 2, 5, 0, "R1");
    diagRead(0, 0, 255, 0, "R1");

    wrAddr(32'hFFFF_FFFF, "R2");
    rdReg(0, "R2");
    wrAddr(32'h1234_5678, "R2");
    rdReg(0, "R2");

    regWrEn = 1; regAddrSel = 1; regWrData = 32'hFFFF_FFFF; tick("R10");
    rdReg(0, "R10");
    rdReg(1, "R10");

    for (int w = 0; w < 4; w++) doFill(w, 20'hA0000 + 20'(w), 16, 10 + w, w == 2, "R7");
    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 4; k++) diagRead(1, w, 16, k, "R3");
    for (int w = 0; w < 4; w++) diagRead(0, w, 16, 0, "R4");

    doLookup(20'hA0001, 16, "R8");
    diagRead(0, 0, 16, 0, "R5");
    doLookup(20'hA0000, 16, "R8");
    diagRead(0, 3, 16, 0, "R5");
    doLookup(20'hA0002, 16, "R8");
    diagRead(0, 1, 16, 0, "R5");
    doLookup(20'hBBBBB, 16, "R8");
    diagRead(0, 1, 16, 0, "R8");

    for (int i = 0; i < 6; i++) diagRead(i % 2, i % 4, 16, i % 4, "R6");
    diagRead(0, 2, 16, 0, "R6");
    diagRead(1, 3, 16, 3, "R6");

    doFill(1, 20'hCCCCC, 32, 40, 0, "R8");
    doFill(3, 20'hCCCCC, 32, 41, 1, "R8");
    doLookup(20'hCCCCC, 32, "R8");
    diagRead(0, 3, 32, 0, "R8");

    wrAddr(mkDiag(0, 2, 32, 0), "R9");
    regRdEn = 1; regAddrSel = 1;
    fillEn = 1; fillWay = 2; fillLineAddr = {20'hDDDDD, 8'd32}; fillLine = mkLine(50);
    lookupEn = 1; lookupLineAddr = {20'hCCCCC, 8'd32};
    tick("R9");
    rdReg(1, "R9");
    doLookup(20'hDDDDD, 32, "R9");

    doFill(0, 20'h00001, 0, 60, 0, "R7");
    doFill(3, 20'hFFFFF, 255, 61, 1, "R7");
    diagRead(1, 0, 0, 0, "R3");
    diagRead(1, 3, 255, 3, "R3");
    diagRead(0, 3, 255, 0, "R4");
    repeat (3) tick("R3");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule